// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Cycle Controller

This block bridges a synchronous host port to an asynchronous 512K x 8 static memory with active-low chip select, output enable and write enable. The host presents one request at a time on a valid/ready handshake, carrying the address, the direction and, for writes, a data byte. The controller holds the address steady, sequences the three strobes and controls the enable of the data pad driver. For reads it returns the captured byte with a one-cycle valid pulse.

All strobe intervals come from nanosecond figures for a 70 ns or a 100 ns memory. Each figure is converted into whole clock cycles by rounding up against a clock-period parameter. A second parameter picks how a write ends. In one style the write strobe rises first and the chip select follows. In the other the chip select rises first and the write strobe follows. Each style uses its own recovery and data-hold figures.

The data bus is split into output, output-enable and input so that the tristate stays in the pad ring.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted, and in idle, all three strobes are high, the data driver is off, `rd_valid` is low and `req_ready` is high. A reset asserted in the middle of an access returns the block to this state at once.
- R2: Each timing figure is turned into ceil(ns / CLK_PERIOD_NS) cycles. At a 20 ns clock, the 100 ns grade with chip-select-terminated writes gives a 5-cycle read, a 4-cycle write pulse, a driver delay of 2 cycles and a 1-cycle write end phase with a 1-cycle data hold.
- R3: After a read is accepted, `mem_ce_n` and `mem_oe_n` are low and `mem_we_n` is high for RD cycles. RD is the larger of the rounded address-access and output-enable figures: 4 cycles for the default 70 ns grade at 20 ns.
- R4: The read byte is the value on `mem_dq_i` during the last read cycle. It appears on `rd_data` in the next cycle, together with a single-cycle `rd_valid` pulse.
- R5: After a write is accepted, `mem_ce_n` and `mem_we_n` are both low for P cycles, with P = max(rounded write pulse, rounded driver delay + rounded data setup): 4 cycles at the default. `mem_oe_n` stays high for the whole write.
- R6: `mem_dq_oe` rises once the rounded driver delay (2 cycles at default) has passed in the pulse. It stays high to the end of the pulse, plus the rounded data hold after it, and `mem_dq_o` then carries the accepted write byte.
- R7: With CE_TERMINATED=0, `mem_we_n` rises first and `mem_ce_n` stays low through an end phase. With CE_TERMINATED=1, `mem_ce_n` rises first and `mem_we_n` stays low through it. The end phase lasts max(recovery, hold, write cycle minus P, 1) cycles.
- R8: While `mem_ce_n` is low, `mem_addr` equals the address taken at acceptance.
- R9: `req_ready` is low from acceptance to the end of the access. Requests presented meanwhile have no effect on the strobes, address or data. `req_ready` returns in cycle RD+1 after a read and in cycle P+end+1 after a write, and a request can be accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rd_valid | output | 1 | Read byte valid, one cycle |
| rd_data | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_o | output | DATA_W | Data to the pad driver |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_i | input | DATA_W | Data from the pad |

## Verification
The read capture and the return of `req_ready` fall in the same cycle: `rd_valid` rises exactly when the controller becomes free. A new request can arrive just as the previous write's end phase finishes. The bench changes `mem_dq_i` every cycle, so only a capture in the last read cycle yields the expected byte. It also keeps a conflicting request asserted during the busy window. In every cycle of the window it compares the strobes, driver enable, address, ready and read-valid against a pattern built from the rounded cycle counts. Two instances run side by side, one per grade and end style.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_READ   = 2'd1,
      PH_WPULSE = 2'd2,
      PH_WEND   = 2'd3
   } phase_e;

   typedef enum logic [3:0] {
      TM_ACC, TM_OE, TM_WC, TM_WP, TM_DS, TM_ODW,
      TM_WR_WE, TM_WR_CE, TM_DH_WE, TM_DH_CE
   } tsel_e;

   function automatic int unsigned grade_ns(input int unsigned grade, input tsel_e sel);
      logic slow;
      slow = (grade == 100);
      case (sel)
         TM_ACC:   return slow ? 100 : 70;
         TM_OE:    return slow ? 50  : 35;
         TM_WC:    return slow ? 100 : 70;
         TM_WP:    return slow ? 75  : 55;
         TM_DS:    return slow ? 40  : 30;
         TM_ODW:   return slow ? 35  : 25;
         TM_WR_WE: return 5;
         TM_WR_CE: return 15;
         TM_DH_WE: return 0;
         TM_DH_CE: return 10;
         default:  return 0;
      endcase
   endfunction

   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
      return (ns + period - 1) / period;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   output logic [CNT_W-1:0] elapsed
);

   if (CNT_W < 1) begin : g_bad_width
      $error("sram_phase_timer: CNT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       elapsed <= '0;
      else if (restart) elapsed <= '0;
      else              elapsed <= elapsed + CNT_W'(1);
   end

endmodule

// File: rtl/sram_io_path.sv
module sram_io_path #(
   parameter int unsigned ADDR_W = 19,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              capture,
   input  logic              drive_en,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_io_path: widths must be non-zero");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_dq_o <= '0;
      end else if (load) begin
         mem_addr <= ld_addr;
         mem_dq_o <= ld_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= capture;
         if (capture) rd_data <= mem_dq_i;
      end
   end

   assign mem_dq_oe = drive_en;

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
   import sram_seq_pkg::*;
#(
   parameter int unsigned ADDR_W        = 19,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_NS = 20,
   parameter int unsigned SPEED_GRADE   = 70,
   parameter bit          CE_TERMINATED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);

   // nanosecond figures rounded up to whole clock cycles
   localparam int unsigned ACC_CYC = ns_to_cyc(grade_ns(SPEED_GRADE, TM_ACC), CLK_PERIOD_NS);
   localparam int unsigned OE_CYC  = ns_to_cyc(grade_ns(SPEED_GRADE, TM_OE), CLK_PERIOD_NS);
   localparam int unsigned WC_CYC  = ns_to_cyc(grade_ns(SPEED_GRADE, TM_WC), CLK_PERIOD_NS);
   localparam int unsigned WP_CYC  = ns_to_cyc(grade_ns(SPEED_GRADE, TM_WP), CLK_PERIOD_NS);
   localparam int unsigned DS_CYC  = ns_to_cyc(grade_ns(SPEED_GRADE, TM_DS), CLK_PERIOD_NS);
   localparam int unsigned ODW_CYC = ns_to_cyc(grade_ns(SPEED_GRADE, TM_ODW), CLK_PERIOD_NS);
   localparam int unsigned WR_CYC  = ns_to_cyc(grade_ns(SPEED_GRADE,
                                     CE_TERMINATED ? TM_WR_CE : TM_WR_WE), CLK_PERIOD_NS);
   localparam int unsigned DH_CYC  = ns_to_cyc(grade_ns(SPEED_GRADE,
                                     CE_TERMINATED ? TM_DH_CE : TM_DH_WE), CLK_PERIOD_NS);

   localparam int unsigned RD_CYC    = umax(umax(ACC_CYC, OE_CYC), 1);
   localparam int unsigned PULSE_CYC = umax(umax(WP_CYC, ODW_CYC + DS_CYC), 1);
   localparam int unsigned WC_REST   = (WC_CYC > PULSE_CYC) ? WC_CYC - PULSE_CYC : 0;
   localparam int unsigned END_CYC   = umax(umax(WR_CYC, DH_CYC), umax(WC_REST, 1));
   localparam int unsigned MAX_CYC   = umax(RD_CYC, umax(PULSE_CYC, END_CYC));
   localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

   localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] END_LAST   = CNT_W'(END_CYC - 1);
   localparam logic [CNT_W-1:0] ODW_CNT    = CNT_W'(ODW_CYC);
   localparam logic [CNT_W-1:0] DH_CNT     = CNT_W'(DH_CYC);

   if (SPEED_GRADE != 70 && SPEED_GRADE != 100) begin : g_bad_grade
      $error("sram_strobe_ctrl: SPEED_GRADE must be 70 or 100");
   end
   if (CLK_PERIOD_NS == 0) begin : g_bad_clk
      $error("sram_strobe_ctrl: CLK_PERIOD_NS must be non-zero");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_strobe_ctrl: widths must be non-zero");
   end

   phase_e           phase, nxt_phase;
   logic [CNT_W-1:0] elapsed;
   logic             restart, accept, capture;
   logic             pulse_drive, hold_drive;
   logic             in_read, in_pulse, in_end;

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= nxt_phase;
   end

   always_comb begin
      nxt_phase = phase;
      accept    = 1'b0;
      capture   = 1'b0;
      case (phase)
         PH_IDLE: begin
            if (req_valid) begin
               accept    = 1'b1;
               nxt_phase = req_write ? PH_WPULSE : PH_READ;
            end
         end
         PH_READ: begin
            if (elapsed == RD_LAST) begin
               capture   = 1'b1;
               nxt_phase = PH_IDLE;
            end
         end
         PH_WPULSE: if (elapsed == PULSE_LAST) nxt_phase = PH_WEND;
         PH_WEND:   if (elapsed == END_LAST)   nxt_phase = PH_IDLE;
         default:   nxt_phase = PH_IDLE;
      endcase
      restart = (nxt_phase != phase);
   end

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .elapsed (elapsed)
   );

   // ---------------- strobe decode ----------------
   assign in_read   = (phase == PH_READ);
   assign in_pulse  = (phase == PH_WPULSE);
   assign in_end    = (phase == PH_WEND);
   assign req_ready = (phase == PH_IDLE);
   assign mem_oe_n  = !in_read;

   if (CE_TERMINATED) begin : g_ce_end
      assign mem_ce_n = !(in_read || in_pulse);
      assign mem_we_n = !(in_pulse || in_end);
   end else begin : g_we_end
      assign mem_ce_n = !(in_read || in_pulse || in_end);
      assign mem_we_n = !in_pulse;
   end

   if (ODW_CYC == 0) begin : g_drive_now
      assign pulse_drive = in_pulse;
   end else begin : g_drive_late
      assign pulse_drive = in_pulse && (elapsed >= ODW_CNT);
   end

   if (DH_CYC == 0) begin : g_no_hold
      assign hold_drive = 1'b0;
   end else begin : g_hold
      assign hold_drive = in_end && (elapsed < DH_CNT);
   end

   sram_io_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .ld_addr   (req_addr),
      .ld_data   (req_wdata),
      .capture   (capture),
      .drive_en  (pulse_drive || hold_drive),
      .mem_dq_i  (mem_dq_i),
      .mem_addr  (mem_addr),
      .mem_dq_o  (mem_dq_o),
      .mem_dq_oe (mem_dq_oe),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

   // ---------------- assertions ----------------
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

   assert_read_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_ce_n && mem_we_n));

   assert_rdv_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   assert_oe_off_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);

   assert_drive_safe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (mem_oe_n && (!mem_we_n || !mem_ce_n)));

   if (CE_TERMINATED) begin : g_chk_ce_end
      assert_ce_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(mem_we_n) |-> $past(mem_ce_n));
   end else begin : g_chk_we_end
      assert_we_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(mem_ce_n) |-> $past(mem_we_n));
   end

   assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

   assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n || !mem_we_n) |-> !req_ready);

endmodule

// File: tb/sram_strobe_ctrl_bench.sv
module sram_strobe_ctrl_bench;

   localparam int unsigned PER = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [18:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic [7:0]  mem_dq_i = '0;

   logic        a_ready, a_rv, a_ce, a_oe, a_we, a_doe;
   logic [7:0]  a_rdd, a_dqo;
   logic [18:0] a_addr;
   logic        b_ready, b_rv, b_ce, b_oe, b_we, b_doe;
   logic [7:0]  b_rdd, b_dqo;
   logic [18:0] b_addr;

   int checks = 0;
   int errors = 0;

   always #(PER/2) clk = ~clk;

   sram_strobe_ctrl u_sram_strobe_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(a_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(a_rv), .rd_data(a_rdd), .mem_addr(a_addr), .mem_ce_n(a_ce),
      .mem_oe_n(a_oe), .mem_we_n(a_we), .mem_dq_o(a_dqo), .mem_dq_oe(a_doe),
      .mem_dq_i(mem_dq_i));

   sram_strobe_ctrl #(.SPEED_GRADE(100), .CE_TERMINATED(1'b1)) u_sram_strobe_ctrl_slow (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(b_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(b_rv), .rd_data(b_rdd), .mem_addr(b_addr), .mem_ce_n(b_ce),
      .mem_oe_n(b_oe), .mem_we_n(b_we), .mem_dq_o(b_dqo), .mem_dq_oe(b_doe),
      .mem_dq_i(mem_dq_i));

   // expected cycle counts from the requirements (R2 rounding)
   function automatic int cdiv(input int ns);
      return (ns + PER - 1) / PER;
   endfunction
   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int A_RD  = 4, A_PULSE = 4, A_ODW = 2, A_DH = 0, A_END = 1;

   int b_rd, b_pulse, b_odw, b_dh, b_end;

   // {write, addr, wdata, response seed}
   localparam logic [35:0] VECS [6] = '{
      {1'b1, 19'h00000, 8'hA5, 8'h00},
      {1'b0, 19'h00000, 8'h00, 8'h3C},
      {1'b1, 19'h7FFFF, 8'h5A, 8'h00},
      {1'b0, 19'h7FFFF, 8'h00, 8'hC3},
      {1'b1, 19'h2AAAA, 8'hFF, 8'h00},
      {1'b0, 19'h55555, 8'h00, 8'h81}
   };

   task automatic expect_eq(input string who, input string tag, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s %s: actual %0h expected %0h", tag, who, what, act, exp);
      end
   endtask

   task automatic check_cycle(input string who, input int c, input bit wr,
      input logic [18:0] addr, input logic [7:0] wd, input logic [7:0] rsp,
      input int rd, input int pulse, input int odw, input int dh, input int endl,
      input bit cestyle, input logic ce, input logic oe, input logic we,
      input logic doe, input logic [7:0] dqo, input logic rdy,
      input logic [18:0] ma, input logic rv, input logic [7:0] rdd);
      logic ece, eoe, ewe, edoe, erdy, erv, in_p, in_e;
      string stag;
      if (!wr) begin
         ece = (c > rd); eoe = ece; ewe = 1'b1; edoe = 1'b0;
         erdy = (c > rd); erv = (c == rd + 1); stag = "R3";
      end else begin
         in_p = (c <= pulse);
         in_e = (c > pulse) && (c <= pulse + endl);
         ece  = !(in_p || (in_e && !cestyle));
         ewe  = !(in_p || (in_e && cestyle));
         eoe  = 1'b1;
         edoe = (in_p && c > odw) || (c > pulse && c <= pulse + dh);
         erdy = (c > pulse + endl); erv = 1'b0;
         stag = in_e ? "R7" : "R5";
      end
      expect_eq(who, stag, $sformatf("ce_n c%0d", c), 32'(ce), 32'(ece));
      expect_eq(who, stag, $sformatf("oe_n c%0d", c), 32'(oe), 32'(eoe));
      expect_eq(who, stag, $sformatf("we_n c%0d", c), 32'(we), 32'(ewe));
      expect_eq(who, "R6", $sformatf("dq_oe c%0d", c), 32'(doe), 32'(edoe));
      if (edoe) expect_eq(who, "R6", "dq_o", 32'(dqo), 32'(wd));
      if (!ece) expect_eq(who, "R8", "mem_addr", 32'(ma), 32'(addr));
      expect_eq(who, "R9", $sformatf("ready c%0d", c), 32'(rdy), 32'(erdy));
      expect_eq(who, "R4", $sformatf("rd_valid c%0d", c), 32'(rv), 32'(erv));
      if (erv) expect_eq(who, "R4", "rd_data", 32'(rdd), 32'(rsp ^ 8'(rd)));
   endtask

   // one access; a conflicting request is held during cycles 1..2 (R9)
   task automatic run_txn(input bit wr, input logic [18:0] addr,
                          input logic [7:0] wd, input logic [7:0] rsp);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
      @(negedge clk);
      for (int c = 1; c <= 8; c++) begin
         check_cycle("fast", c, wr, addr, wd, rsp, A_RD, A_PULSE, A_ODW, A_DH, A_END, 1'b0,
                     a_ce, a_oe, a_we, a_doe, a_dqo, a_ready, a_addr, a_rv, a_rdd);
         check_cycle("slow(R2)", c, wr, addr, wd, rsp, b_rd, b_pulse, b_odw, b_dh, b_end, 1'b1,
                     b_ce, b_oe, b_we, b_doe, b_dqo, b_ready, b_addr, b_rv, b_rdd);
         mem_dq_i = rsp ^ 8'(c);
         if (c == 1) begin
            req_write = !wr; req_addr = ~addr; req_wdata = ~wd;
         end
         if (c == 3) req_valid = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic check_idle(input string when);
      expect_eq(when, "R1", "fast strobes", 32'({a_ce, a_oe, a_we}), 32'(3'b111));
      expect_eq(when, "R1", "fast drive/ready/rv", 32'({a_doe, a_ready, a_rv}), 32'(3'b010));
      expect_eq(when, "R1", "slow strobes", 32'({b_ce, b_oe, b_we}), 32'(3'b111));
      expect_eq(when, "R1", "slow drive/ready/rv", 32'({b_doe, b_ready, b_rv}), 32'(3'b010));
   endtask

   initial begin
      #(PER * 200000);
      checks++; errors++;
      $display("FAIL R9 watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      b_rd    = imax(cdiv(100), cdiv(50));
      b_pulse = imax(cdiv(75), cdiv(35) + cdiv(40));
      b_odw   = cdiv(35);
      b_dh    = cdiv(10);
      b_end   = imax(imax(cdiv(15), b_dh), imax(cdiv(100) - b_pulse, 1));
      // R2: rounded counts for the slow instance
      expect_eq("slow", "R2", "read cycles", 32'(b_rd), 32'd5);
      expect_eq("slow", "R2", "pulse cycles", 32'(b_pulse), 32'd4);

      // R1: reset state
      repeat (3) @(negedge clk);
      check_idle("in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("after reset");

      // table walk
      for (int i = 0; i < 6; i++) begin
         run_txn(VECS[i][35], VECS[i][34:16], VECS[i][15:8], VECS[i][7:0]);
      end

      // R1: reset in the middle of a write pulse
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h12345; req_wdata = 8'h66;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      expect_eq("mid-write", "R5", "we_n low before reset", 32'(a_we), 32'd0);
      rst_n = 1'b0;
      #1;
      check_idle("mid-write reset");
      @(negedge clk);
      rst_n = 1'b1;

      // recovery after reset, boundary address
      run_txn(1'b0, 19'h7FFFF, 8'h00, 8'h7E);
      run_txn(1'b1, 19'h00001, 8'h01, 8'h00);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule